// File: doc/BRIEF.md
# USB Endpoint Transfer-Size Tracker

This block keeps the transfer counters for two endpoints of a USB device controller: a control OUT endpoint and an IN endpoint that can run periodic traffic. Software loads each endpoint's counters through a small register port while the endpoint is idle, then sets the endpoint's enable bit. From then on the counters belong to the hardware. The hardware updates them on packet-done strobes that carry the packet's byte length. When a transfer finishes, the hardware clears the enable bit and emits a one-cycle completion pulse.

The control OUT endpoint also keeps a budget of back-to-back SETUP packets. A SETUP that arrives after the budget is spent sets a sticky overflow flag. For the IN endpoint, a per-frame packet multiplier picks the data PID of each packet in the frame. The position in the frame restarts on each start-of-frame strobe. FIFO data movement, DMA, token decoding and the PHY sit outside the block; they appear here only as strobes.

Top module: `usb_ep_xfer_tracker`

## Requirements
- R1: The register port has four word addresses. 0 is OUT control, with enable at bit 0. 1 is OUT size: byte count [6:0], packet count bit 8, SETUP count [10:9]. 2 is IN control, with enable at bit 0. 3 is IN size: byte count [9:0], packet count [19:10], multi count [21:20]. Reads are combinational. Every other bit reads as zero. All fields reset to zero.
- R2: A write to a size register is ignored while that endpoint's enable bit is set. While the bit is clear, the write loads every field of the register.
- R3: An OUT packet-done strobe on an enabled endpoint reduces the byte count by the packet length, saturating at zero, and clears the 1-bit packet count.
- R4: The cycle after a transfer finishes, the matching completion output is high for exactly one cycle and the enable bit reads 0 at the same time. For OUT, every accepted packet finishes the transfer, because its packet count is a single bit.
- R5: A packet-done strobe has no effect on counters or outputs while the endpoint's enable bit is clear.
- R6: Each SETUP strobe lowers the SETUP count by one; codes 1, 2 and 3 allow 1, 2 and 3 SETUPs. A SETUP that arrives at count 0 sets the sticky overflow output. The overflow stays set until software writes the OUT size register. If both happen in the same cycle, the write wins.
- R7: An IN packet-done strobe on an enabled endpoint reduces the byte count by the length, saturating at zero, and lowers the packet count by one. The transfer finishes when either count is zero after the update.
- R8: The IN data PID output (DATA0=0, DATA1=1, DATA2=2) gives the PID of the next packet in the frame. With multi count 3 the sequence is DATA2, DATA1, DATA0. With multi count 2 it is DATA1, DATA0. With multi count 1 or 0 it is DATA0. Packets past the multi count use DATA0.
- R9: A start-of-frame strobe puts the PID sequence back at its first packet. A packet done in the same cycle as the strobe does not advance the sequence.
- R10: A write of 0 to a control register stops that endpoint at once, with no completion pulse, and leaves its counters as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| out_pkt_done | input | 1 | OUT packet moved to memory |
| out_pkt_len | input | 7 | Byte length of that OUT packet |
| setup_rcvd | input | 1 | SETUP packet received |
| in_pkt_done | input | 1 | IN packet read from the transmit FIFO |
| in_pkt_len | input | 10 | Byte length of that IN packet |
| sof | input | 1 | Start-of-frame strobe |
| out_xfer_done | output | 1 | OUT transfer-complete pulse |
| in_xfer_done | output | 1 | IN transfer-complete pulse |
| setup_overflow | output | 1 | Sticky SETUP budget overflow |
| in_data_pid | output | 2 | Data PID of the next IN packet |

## Verification
The hardest case to reach from the ports is where the PID sequence runs past the multiplier and then restarts. The endpoint must stay enabled through every packet of the frame, and the packet count alone must decide when the transfer ends. The stimulus loads a large byte budget with a small packet count, so the packet count expires first, and then pulses start-of-frame after the overflowing packets. A long random phase also fires SETUP, start-of-frame, packet and write strobes together, so that load-versus-update and restart-versus-advance collisions occur against the behavioural model.

// File: rtl/usb_xt_pkg.sv
package usb_xt_pkg;

   typedef enum logic [1:0] {
      PID_DATA0 = 2'd0,
      PID_DATA1 = 2'd1,
      PID_DATA2 = 2'd2
   } data_pid_e;

   localparam logic [1:0] RA_OUT_CTRL = 2'd0;
   localparam logic [1:0] RA_OUT_SIZE = 2'd1;
   localparam logic [1:0] RA_IN_CTRL  = 2'd2;
   localparam logic [1:0] RA_IN_SIZE  = 2'd3;

endpackage

// File: rtl/xt_out_ep.sv
module xt_out_ep #(
   parameter int BYTE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              ctrl_en,
   input  logic              size_wr,
   input  logic [BYTE_W-1:0] ld_bytes,
   input  logic              ld_pkt,
   input  logic [1:0]        ld_setup,
   input  logic              pkt_done,
   input  logic [BYTE_W-1:0] pkt_len,
   input  logic              setup_rcvd,
   output logic              en_o,
   output logic [BYTE_W-1:0] bytes_o,
   output logic              pkt_o,
   output logic [1:0]        setup_o,
   output logic              ovf_o,
   output logic              done_o
);

   logic            accept;
   logic            load;
   logic [BYTE_W:0] diff;

   assign accept = en_o & pkt_done;
   assign load   = size_wr & ~en_o;
   assign diff   = {1'b0, bytes_o} - {1'b0, pkt_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o    <= 1'b0;
         bytes_o <= '0;
         pkt_o   <= 1'b0;
         setup_o <= 2'd0;
         ovf_o   <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= accept;
         if (accept)       en_o <= 1'b0;
         else if (ctrl_wr) en_o <= ctrl_en;

         if (load) begin
            bytes_o <= ld_bytes;
            pkt_o   <= ld_pkt;
         end else if (accept) begin
            bytes_o <= diff[BYTE_W] ? '0 : diff[BYTE_W-1:0];
            pkt_o   <= 1'b0;
         end

         if (load) begin
            setup_o <= ld_setup;
            ovf_o   <= 1'b0;
         end else if (setup_rcvd) begin
            if (setup_o == 2'd0) ovf_o   <= 1'b1;
            else                 setup_o <= setup_o - 2'd1;
         end
      end
   end

endmodule

// File: rtl/xt_in_ep.sv
module xt_in_ep #(
   parameter int BYTE_W = 10,
   parameter int PKT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              ctrl_en,
   input  logic              size_wr,
   input  logic [BYTE_W-1:0] ld_bytes,
   input  logic [PKT_W-1:0]  ld_pkts,
   input  logic [1:0]        ld_mc,
   input  logic              pkt_done,
   input  logic [BYTE_W-1:0] pkt_len,
   output logic              en_o,
   output logic [BYTE_W-1:0] bytes_o,
   output logic [PKT_W-1:0]  pkts_o,
   output logic [1:0]        mc_o,
   output logic              adv_o,
   output logic              done_o
);

   logic              load;
   logic              finish;
   logic [BYTE_W:0]   diff;
   logic [BYTE_W-1:0] bytes_nx;
   logic [PKT_W-1:0]  pkts_nx;

   assign adv_o    = en_o & pkt_done;
   assign load     = size_wr & ~en_o;
   assign diff     = {1'b0, bytes_o} - {1'b0, pkt_len};
   assign bytes_nx = diff[BYTE_W] ? '0 : diff[BYTE_W-1:0];
   assign pkts_nx  = (pkts_o == '0) ? '0 : pkts_o - 1'b1;
   assign finish   = (bytes_nx == '0) || (pkts_nx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o    <= 1'b0;
         bytes_o <= '0;
         pkts_o  <= '0;
         mc_o    <= 2'd0;
         done_o  <= 1'b0;
      end else begin
         done_o <= adv_o & finish;
         if (adv_o && finish) en_o <= 1'b0;
         else if (ctrl_wr)    en_o <= ctrl_en;

         if (load) begin
            bytes_o <= ld_bytes;
            pkts_o  <= ld_pkts;
            mc_o    <= ld_mc;
         end else if (adv_o) begin
            bytes_o <= bytes_nx;
            pkts_o  <= pkts_nx;
         end
      end
   end

endmodule

// File: rtl/xt_pid_seq.sv
module xt_pid_seq
   import usb_xt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sof,
   input  logic      adv,
   input  logic [1:0] mc,
   output data_pid_e pid_o
);

   logic [1:0] idx;
   logic [1:0] mc_eff;

   assign mc_eff = (mc == 2'd0) ? 2'd1 : mc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       idx <= 2'd0;
      else if (sof)                     idx <= 2'd0;
      else if (adv && idx != 2'd3)      idx <= idx + 2'd1;
   end

   always_comb begin
      if (idx >= mc_eff) pid_o = PID_DATA0;
      else               pid_o = data_pid_e'(mc_eff - 2'd1 - idx);
   end

endmodule

// File: rtl/usb_ep_xfer_tracker.sv
module usb_ep_xfer_tracker
   import usb_xt_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 2,
   parameter int OUT_BYTE_W   = 7,
   parameter int IN_BYTE_W    = 10,
   parameter int IN_PKT_W     = 10,
   parameter bit PERIODIC_PID = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  out_pkt_done,
   input  logic [OUT_BYTE_W-1:0] out_pkt_len,
   input  logic                  setup_rcvd,
   input  logic                  in_pkt_done,
   input  logic [IN_BYTE_W-1:0]  in_pkt_len,
   input  logic                  sof,
   output logic                  out_xfer_done,
   output logic                  in_xfer_done,
   output logic                  setup_overflow,
   output logic [1:0]            in_data_pid
);

   localparam int OUT_PKT_BIT   = OUT_BYTE_W + 1;
   localparam int OUT_SETUP_LSB = OUT_BYTE_W + 2;
   localparam int IN_PKT_LSB    = IN_BYTE_W;
   localparam int IN_MC_LSB     = IN_BYTE_W + IN_PKT_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover four registers");
   end
   if (OUT_SETUP_LSB + 2 > DATA_W || IN_MC_LSB + 2 > DATA_W) begin : g_bad_fit
      $error("size fields do not fit DATA_W");
   end
   if (OUT_BYTE_W < 1 || IN_BYTE_W < 1 || IN_PKT_W < 1) begin : g_bad_w
      $error("counter widths must be positive");
   end

   logic                  out_ctrl_wr, out_size_wr, in_ctrl_wr, in_size_wr;
   logic                  out_en, out_pkt;
   logic [OUT_BYTE_W-1:0] out_bytes;
   logic [1:0]            out_setup;
   logic                  in_en, in_adv;
   logic [IN_BYTE_W-1:0]  in_bytes;
   logic [IN_PKT_W-1:0]   in_pkts;
   logic [1:0]            in_mc;

   assign out_ctrl_wr = reg_wr && (reg_addr == ADDR_W'(RA_OUT_CTRL));
   assign out_size_wr = reg_wr && (reg_addr == ADDR_W'(RA_OUT_SIZE));
   assign in_ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(RA_IN_CTRL));
   assign in_size_wr  = reg_wr && (reg_addr == ADDR_W'(RA_IN_SIZE));

   xt_out_ep #(.BYTE_W(OUT_BYTE_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (out_ctrl_wr),
      .ctrl_en    (reg_wdata[0]),
      .size_wr    (out_size_wr),
      .ld_bytes   (reg_wdata[OUT_BYTE_W-1:0]),
      .ld_pkt     (reg_wdata[OUT_PKT_BIT]),
      .ld_setup   (reg_wdata[OUT_SETUP_LSB +: 2]),
      .pkt_done   (out_pkt_done),
      .pkt_len    (out_pkt_len),
      .setup_rcvd (setup_rcvd),
      .en_o       (out_en),
      .bytes_o    (out_bytes),
      .pkt_o      (out_pkt),
      .setup_o    (out_setup),
      .ovf_o      (setup_overflow),
      .done_o     (out_xfer_done)
   );

   xt_in_ep #(.BYTE_W(IN_BYTE_W), .PKT_W(IN_PKT_W)) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (in_ctrl_wr),
      .ctrl_en  (reg_wdata[0]),
      .size_wr  (in_size_wr),
      .ld_bytes (reg_wdata[IN_BYTE_W-1:0]),
      .ld_pkts  (reg_wdata[IN_PKT_LSB +: IN_PKT_W]),
      .ld_mc    (reg_wdata[IN_MC_LSB +: 2]),
      .pkt_done (in_pkt_done),
      .pkt_len  (in_pkt_len),
      .en_o     (in_en),
      .bytes_o  (in_bytes),
      .pkts_o   (in_pkts),
      .mc_o     (in_mc),
      .adv_o    (in_adv),
      .done_o   (in_xfer_done)
   );

   if (PERIODIC_PID) begin : g_pid
      data_pid_e pid;
      xt_pid_seq u_pid (
         .clk   (clk),
         .rst_n (rst_n),
         .sof   (sof),
         .adv   (in_adv),
         .mc    (in_mc),
         .pid_o (pid)
      );
      assign in_data_pid = pid;
   end else begin : g_no_pid
      assign in_data_pid = PID_DATA0;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr[1:0])
         RA_OUT_CTRL: reg_rdata[0] = out_en;
         RA_OUT_SIZE: begin
            reg_rdata[OUT_BYTE_W-1:0]       = out_bytes;
            reg_rdata[OUT_PKT_BIT]          = out_pkt;
            reg_rdata[OUT_SETUP_LSB +: 2]   = out_setup;
         end
         RA_IN_CTRL:  reg_rdata[0] = in_en;
         default: begin
            reg_rdata[IN_BYTE_W-1:0]        = in_bytes;
            reg_rdata[IN_PKT_LSB +: IN_PKT_W] = in_pkts;
            reg_rdata[IN_MC_LSB +: 2]       = in_mc;
         end
      endcase
   end

endmodule

// File: rtl/xt_checker.sv
module xt_checker #(
   parameter int OUT_BYTE_W = 7,
   parameter int IN_PKT_W   = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  out_en,
   input logic                  in_en,
   input logic                  out_done,
   input logic                  in_done,
   input logic [OUT_BYTE_W-1:0] out_bytes,
   input logic [IN_PKT_W-1:0]   in_pkts,
   input logic [1:0]            setup_cnt,
   input logic                  setup_rcvd,
   input logic                  out_size_wr,
   input logic                  out_pkt_done,
   input logic                  setup_ovf,
   input logic                  sof,
   input logic [1:0]            in_mc,
   input logic [1:0]            in_pid
);

   AST_OUT_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> !out_en); // R4
   AST_IN_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      in_done |-> !in_en); // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done); // R4
   AST_OUT_BYTES_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(out_en) |-> out_bytes <= $past(out_bytes)); // R3
   AST_IN_PKTS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_en) |-> in_pkts <= $past(in_pkts)); // R7
   AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && out_pkt_done && !out_size_wr) |=> $stable(out_bytes)); // R5
   AST_SETUP_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_rcvd && setup_cnt == 2'd0 && !out_size_wr) |=> setup_ovf); // R6
   AST_PID_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sof) |-> in_pid == ((in_mc == 2'd0) ? 2'd0 : in_mc - 2'd1)); // R9

endmodule

bind usb_ep_xfer_tracker xt_checker #(
   .OUT_BYTE_W (OUT_BYTE_W),
   .IN_PKT_W   (IN_PKT_W)
) u_xt_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .out_en       (out_en),
   .in_en        (in_en),
   .out_done     (out_xfer_done),
   .in_done      (in_xfer_done),
   .out_bytes    (out_bytes),
   .in_pkts      (in_pkts),
   .setup_cnt    (out_setup),
   .setup_rcvd   (setup_rcvd),
   .out_size_wr  (out_size_wr),
   .out_pkt_done (out_pkt_done),
   .setup_ovf    (setup_overflow),
   .sof          (sof),
   .in_mc        (in_mc),
   .in_pid       (in_data_pid)
);

// File: tb/test_usb_ep_xfer_tracker.sv
`timescale 1ns/10ps
module test_usb_ep_xfer_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        out_pkt_done = 1'b0;
   logic [6:0]  out_pkt_len = '0;
   logic        setup_rcvd = 1'b0;
   logic        in_pkt_done = 1'b0;
   logic [9:0]  in_pkt_len = '0;
   logic        sof = 1'b0;
   logic        out_xfer_done, in_xfer_done, setup_overflow;
   logic [1:0]  in_data_pid;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   usb_ep_xfer_tracker i_usb_ep_xfer_tracker (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .out_pkt_done(out_pkt_done), .out_pkt_len(out_pkt_len),
      .setup_rcvd(setup_rcvd), .in_pkt_done(in_pkt_done),
      .in_pkt_len(in_pkt_len), .sof(sof),
      .out_xfer_done(out_xfer_done), .in_xfer_done(in_xfer_done),
      .setup_overflow(setup_overflow), .in_data_pid(in_data_pid)
   );

   // behavioural reference model
   int m_oen, m_obytes, m_opkt, m_osetup, m_ovf, m_odone;
   int m_ien, m_ibytes, m_ipkts, m_imc, m_idone, m_iidx;

   function automatic int pid_of(int mc, int idx);
      int me;
      me = (mc == 0) ? 1 : mc;
      return (idx >= me) ? 0 : me - 1 - idx;
   endfunction

   function automatic int model_read(int a);
      case (a)
         0: return m_oen;
         1: return m_obytes + (m_opkt << 8) + (m_osetup << 9);
         2: return m_ien;
         default: return m_ibytes + (m_ipkts << 10) + (m_imc << 20);
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_oen = 0; m_obytes = 0; m_opkt = 0; m_osetup = 0; m_ovf = 0; m_odone = 0;
         m_ien = 0; m_ibytes = 0; m_ipkts = 0; m_imc = 0; m_idone = 0; m_iidx = 0;
      end else begin
         int oen_n, ien_n, nb, np;
         // OUT endpoint
         oen_n = m_oen;
         m_odone = 0;
         if (reg_wr && reg_addr == 2'd0) oen_n = int'(reg_wdata[0]);
         if (reg_wr && reg_addr == 2'd1 && m_oen == 0) begin
            m_obytes = int'(reg_wdata[6:0]);
            m_opkt   = int'(reg_wdata[8]);
            m_osetup = int'(reg_wdata[10:9]);
            m_ovf    = 0;
         end else begin
            if (setup_rcvd) begin
               if (m_osetup == 0) m_ovf = 1;
               else m_osetup = m_osetup - 1;
            end
            if (m_oen != 0 && out_pkt_done) begin
               nb = m_obytes - int'(out_pkt_len);
               m_obytes = (nb < 0) ? 0 : nb;
               m_opkt = 0;
               m_odone = 1;
               oen_n = 0;
            end
         end
         // IN endpoint
         ien_n = m_ien;
         m_idone = 0;
         if (reg_wr && reg_addr == 2'd2) ien_n = int'(reg_wdata[0]);
         if (sof) m_iidx = 0;
         else if (m_ien != 0 && in_pkt_done && m_iidx < 3) m_iidx = m_iidx + 1;
         if (reg_wr && reg_addr == 2'd3 && m_ien == 0) begin
            m_ibytes = int'(reg_wdata[9:0]);
            m_ipkts  = int'(reg_wdata[19:10]);
            m_imc    = int'(reg_wdata[21:20]);
         end else if (m_ien != 0 && in_pkt_done) begin
            nb = m_ibytes - int'(in_pkt_len);
            m_ibytes = (nb < 0) ? 0 : nb;
            np = (m_ipkts == 0) ? 0 : m_ipkts - 1;
            m_ipkts = np;
            if (m_ibytes == 0 || m_ipkts == 0) begin
               m_idone = 1;
               ien_n = 0;
            end
         end
         m_oen = oen_n;
         m_ien = ien_n;
      end
   end

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R1 readback", reg_rdata, model_read(int'(reg_addr)));
         chk("R4 out done", out_xfer_done, m_odone);
         chk("R7 in done", in_xfer_done, m_idone);
         chk("R6 overflow", setup_overflow, m_ovf);
         chk("R8 pid", in_data_pid, pid_of(m_imc, m_iidx));
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output longint d);
      reg_addr = a;
      #0.1;
      d = reg_rdata;
   endtask

   task automatic out_pkt(input int len);
      out_pkt_done = 1'b1; out_pkt_len = 7'(len);
      tick();
      out_pkt_done = 1'b0;
   endtask

   task automatic in_pkt(input int len);
      in_pkt_done = 1'b1; in_pkt_len = 10'(len);
      tick();
      in_pkt_done = 1'b0;
   endtask

   task automatic setup_pulse();
      setup_rcvd = 1'b1;
      tick();
      setup_rcvd = 1'b0;
   endtask

   task automatic sof_pulse();
      sof = 1'b1;
      tick();
      sof = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL R4 watchdog: actual %0d cycles expected fewer", 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      longint v;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v); chk("R1 reset read", v, 0);
      end
      chk("R6 reset overflow", setup_overflow, 0);
      chk("R8 reset pid", in_data_pid, 0);

      // R1 field layout and reserved bits
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); chk("R1 reserved zero", v, 1919);
      wr(2'd1, 1856);
      rd(2'd1, v); chk("R1 out size", v, 1856);
      wr(2'd0, 1);
      rd(2'd0, v); chk("R1 out enable", v, 1);
      wr(2'd1, 5);
      rd(2'd1, v); chk("R2 write ignored while enabled", v, 1856);

      // R3 / R4 one full packet
      out_pkt(64);
      chk("R4 out done pulse", out_xfer_done, 1);
      rd(2'd0, v); chk("R4 enable cleared", v, 0);
      rd(2'd1, v); chk("R3 counts after packet", v, 1536);
      tick();
      chk("R4 pulse one cycle", out_xfer_done, 0);

      // R3 saturation
      wr(2'd1, 10 + 256);
      wr(2'd0, 1);
      out_pkt(30);
      rd(2'd1, v); chk("R3 saturate at zero", v, 0);

      // R5 strobe while disabled
      wr(2'd1, 20 + 256);
      out_pkt(5);
      chk("R5 no done while idle", out_xfer_done, 0);
      rd(2'd1, v); chk("R5 counts untouched", v, 276);

      // R6 SETUP budget
      wr(2'd1, 2 << 9);
      setup_pulse();
      rd(2'd1, v); chk("R6 first setup", v, 512);
      setup_pulse();
      rd(2'd1, v); chk("R6 second setup", v, 0);
      chk("R6 no overflow yet", setup_overflow, 0);
      setup_pulse();
      chk("R6 overflow set", setup_overflow, 1);
      tick();
      chk("R6 overflow sticky", setup_overflow, 1);
      wr(2'd1, 3 << 9);
      chk("R6 overflow cleared by load", setup_overflow, 0);
      rd(2'd1, v); chk("R6 reload", v, 1536);

      // R7 / R8 IN with multi count 3
      wr(2'd3, 100 + (3 << 10) + (3 << 20));
      rd(2'd3, v); chk("R1 in size", v, 3148900);
      wr(2'd2, 1);
      chk("R8 first pid DATA2", in_data_pid, 2);
      in_pkt(40);
      chk("R8 second pid DATA1", in_data_pid, 1);
      chk("R7 not done", in_xfer_done, 0);
      rd(2'd3, v); chk("R7 counts after one", v, 3147836);
      in_pkt(40);
      chk("R8 third pid DATA0", in_data_pid, 0);
      in_pkt(20);
      chk("R7 done on bytes", in_xfer_done, 1);
      rd(2'd2, v); chk("R4 in enable cleared", v, 0);
      rd(2'd3, v); chk("R7 bytes zero", v, 3145728);
      sof_pulse();
      chk("R9 restart DATA2", in_data_pid, 2);

      // R7 packet count ends first, R8 beyond multi count, R9 restart
      wr(2'd3, 500 + (2 << 10) + (2 << 20));
      sof_pulse();
      wr(2'd2, 1);
      chk("R8 mc2 first DATA1", in_data_pid, 1);
      in_pkt(10);
      chk("R8 mc2 second DATA0", in_data_pid, 0);
      chk("R7 not done yet", in_xfer_done, 0);
      in_pkt(10);
      chk("R7 done on packet count", in_xfer_done, 1);
      rd(2'd3, v); chk("R7 bytes left", v, 2097632);
      chk("R8 beyond multi count", in_data_pid, 0);
      sof_pulse();
      chk("R9 restart DATA1", in_data_pid, 1);

      // R8 multi count 1 and 0
      wr(2'd3, (1 << 20) + 50);
      chk("R8 mc1 DATA0", in_data_pid, 0);
      wr(2'd3, 50);
      chk("R8 mc0 DATA0", in_data_pid, 0);

      // R10 abort
      wr(2'd3, 50 + (5 << 10));
      wr(2'd2, 1);
      wr(2'd2, 0);
      chk("R10 no in pulse", in_xfer_done, 0);
      rd(2'd2, v); chk("R10 in stopped", v, 0);
      rd(2'd3, v); chk("R10 in counts kept", v, 5170);
      wr(2'd1, 64 + 256);
      wr(2'd0, 1);
      wr(2'd0, 0);
      out_pkt(8);
      chk("R10 no out pulse", out_xfer_done, 0);
      rd(2'd1, v); chk("R10 out counts kept", v, 320);

      // random phase against the model
      for (int i = 0; i < 3000; i++) begin
         reg_wr       = ($urandom_range(0, 3) == 0);
         reg_addr     = 2'($urandom_range(0, 3));
         reg_wdata    = $urandom;
         if ($urandom_range(0, 1) == 0) reg_wdata[0] = 1'b1;
         out_pkt_done = ($urandom_range(0, 3) == 0);
         out_pkt_len  = 7'($urandom_range(0, 80));
         setup_rcvd   = ($urandom_range(0, 5) == 0);
         in_pkt_done  = ($urandom_range(0, 2) == 0);
         in_pkt_len   = 10'($urandom_range(0, 300));
         sof          = ($urandom_range(0, 7) == 0);
         tick();
      end
      reg_wr = 1'b0; out_pkt_done = 1'b0; setup_rcvd = 1'b0;
      in_pkt_done = 1'b0; sof = 1'b0;
      repeat (2) tick();

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule